// File: doc/BRIEF.md
# Dual-DAC Converter Host Bus Front End

This block is the parallel host-side front end of a combined converter that has one successive-approximation ADC and two 8-bit DACs. A host drives an active-low select, an active-low write strobe and an active-low read strobe. It also drives a function line that chooses the ADC or the DAC side, and a channel line that chooses channel A or B. A write to the ADC side starts a conversion on the selected input. A write to the DAC side loads one of the two DAC registers, either from the bus or straight from the last ADC result. A read drives the latched ADC result onto the data port.

All pins are sampled in the chip's clock domain. The block looks for strobe edges itself. A small sequencer model holds the selected input when a conversion starts. It hands back a result after a fixed number of clocks. The end-of-conversion flag then goes low and stays low until the host reads. The data port is split into an input bus, an output bus and an output enable, so the pad ring can build the tristate pin.

Top module: `dual_conv_bus`

## Requirements
- R1: After reset, both DAC registers and the ADC result latch are zero, the end-of-conversion flag `eocN` is high, the ADC channel register is 0 (channel A), and `busOe` is low.
- R2: While `csN` is high, a write strobe has no effect: the DAC registers keep their values and no conversion starts.
- R3: With `funcAdc`=1 and `csN` low, a low-to-high transition of `wrN` starts a conversion. `eocN` falls on the CONV_CYCLES-th clock edge after the edge that first samples `wrN` high.
- R4: The value of `chanB` at the start edge (0 = input A, 1 = input B) is stored in `adcChan` and held for the whole conversion. The result equals the selected input as sampled on that start edge, even if that input changes later.
- R5: With `funcAdc`=0, `xferAdc`=0 and `csN` low, a rising `wrN` loads `busIn` into `dacA` when `chanB`=0, or into `dacB` when `chanB`=1. The other register keeps its value.
- R6: With `funcAdc`=0 and `xferAdc`=1, a rising `wrN` loads the ADC result latch into the DAC register that `chanB` selects, and ignores `busIn`.
- R7: `busOe` is high exactly while both `csN` and `rdN` are low, and `busOut` then carries the ADC result latch.
- R8: If `csN` and `rdN` are held low through a conversion, the port shows the previous result up to the cycle before `eocN` falls, and shows the new result from the cycle in which `eocN` falls.
- R9: Once low, `eocN` returns high only on the clock edge that sees a falling `rdN` while `csN` is low. A read with `csN` high leaves it low.
- R10: An ADC-side write during a conversion is ignored: the channel register, the result and the completion time of the running conversion are unchanged.
- R11: If `rdN` stays high during a conversion, `busOe` stays low for the whole conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low device select |
| wrN | input | 1 | Active-low write strobe; actions occur on its rising edge |
| rdN | input | 1 | Active-low read strobe |
| funcAdc | input | 1 | 1 = ADC side, 0 = DAC side |
| chanB | input | 1 | 0 = channel A, 1 = channel B |
| xferAdc | input | 1 | On a DAC write, load the ADC result instead of the bus |
| adcInA | input | 8 | Digital stand-in for held input A |
| adcInB | input | 8 | Digital stand-in for held input B |
| busIn | input | 8 | Data port, host to block |
| busOut | output | 8 | Data port, block to host (ADC result latch) |
| busOe | output | 1 | Data port drive enable |
| eocN | output | 1 | Active-low end-of-conversion flag |
| dacA | output | 8 | DAC register A |
| dacB | output | 8 | DAC register B |
| adcChan | output | 1 | Channel register driving the input multiplexer |

## Verification
On every cycle, the assertions check four things. The channel register holds still while a conversion runs. A DAC register changes only after a DAC load strobe. The result latch moves only when the sequencer reports completion. The flag falls only after completion and rises only after a qualified read. Only the bench scenarios can show the rest: the exact completion cycle, which input value was held, and the bus switching from the old result to the new one in a held read. They also show that writes with select high, or writes during a conversion, change nothing that is visible at the ports.

// File: rtl/dual_conv_bus_pkg.sv
package dual_conv_bus_pkg;
  typedef struct packed {
    logic convStart;  // begin a conversion this cycle
    logic convChan;   // channel to capture with convStart
    logic dacLoad;    // load a DAC register this cycle
    logic dacSelB;    // 0 = register A, 1 = register B
    logic useAdc;     // load source: ADC latch instead of bus
    logic eocClear;   // qualified read edge seen
  } busStrobes_t;
endpackage

// File: rtl/dual_conv_bus_ctrl.sv
module dual_conv_bus_ctrl
  import dual_conv_bus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        wrN,
  input  logic        rdN,
  input  logic        funcAdc,
  input  logic        chanB,
  input  logic        xferAdc,
  input  logic        convBusy,
  output busStrobes_t strb,
  output logic        busOe
);
  logic wrPrev;
  logic rdPrev;
  logic wrRise;
  logic rdFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b1;
      rdPrev <= 1'b1;
    end else begin
      wrPrev <= wrN;
      rdPrev <= rdN;
    end
  end

  assign wrRise = !wrPrev && wrN && !csN;
  assign rdFall = rdPrev && !rdN && !csN;

  always_comb begin
    strb.convStart = wrRise && funcAdc && !convBusy;
    strb.convChan  = chanB;
    strb.dacLoad   = wrRise && !funcAdc;
    strb.dacSelB   = chanB;
    strb.useAdc    = xferAdc;
    strb.eocClear  = rdFall;
  end

  assign busOe = !csN && !rdN;
endmodule

// File: rtl/dual_conv_seq.sv
module dual_conv_seq #(
  parameter int DATA_W      = 8,
  parameter int CONV_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              chan,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] held;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      held <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_LAST;
      held <= chan ? inB : inA;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done   = busy && (cnt == '0);
  assign result = held;
endmodule

// File: rtl/dual_conv_bus_dpath.sv
module dual_conv_bus_dpath
  import dual_conv_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobes_t       strb,
  input  logic [DATA_W-1:0] busIn,
  input  logic              convBusy,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convResult,
  output logic [DATA_W-1:0] dacA,
  output logic [DATA_W-1:0] dacB,
  output logic [DATA_W-1:0] adcLatch,
  output logic              chanReg,
  output logic              eocN
);
  localparam int NUM_DAC = 2;

  logic [DATA_W-1:0] dacReg [NUM_DAC];
  logic [DATA_W-1:0] loadVal;

  assign loadVal = strb.useAdc ? adcLatch : busIn;

  for (genvar g = 0; g < NUM_DAC; g++) begin : g_dac
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          dacReg[g] <= '0;
      else if (strb.dacLoad && (strb.dacSelB == (g == 1))) dacReg[g] <= loadVal;
    end
    // R5, R6: a register moves only after a load strobe
    a_r5_dac_quiet: assert property (@(posedge clk) disable iff (!rstN)
      !$past(strb.dacLoad) |-> $stable(dacReg[g]));
  end

  assign dacA = dacReg[0];
  assign dacB = dacReg[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcLatch <= '0;
      chanReg  <= 1'b0;
      eocN     <= 1'b1;
    end else begin
      if (strb.convStart) chanReg  <= strb.convChan;
      if (convDone)       adcLatch <= convResult;
      if (convDone)           eocN <= 1'b0;
      else if (strb.eocClear) eocN <= 1'b1;
    end
  end

  a_r4_chan_held: assert property (@(posedge clk) disable iff (!rstN)
    (convBusy && $past(convBusy)) |-> $stable(chanReg));
  a_r8_latch_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$past(convDone) |-> $stable(adcLatch));
  a_r3_eoc_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocN) |-> $past(convDone));
  a_r9_eoc_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eocN) |-> $past(strb.eocClear));
endmodule

// File: rtl/dual_conv_bus.sv
module dual_conv_bus
  import dual_conv_bus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CONV_CYCLES = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              funcAdc,
  input  logic              chanB,
  input  logic              xferAdc,
  input  logic [DATA_W-1:0] adcInA,
  input  logic [DATA_W-1:0] adcInB,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              eocN,
  output logic [DATA_W-1:0] dacA,
  output logic [DATA_W-1:0] dacB,
  output logic              adcChan
);
  busStrobes_t       strb;
  logic              convBusy;
  logic              convDone;
  logic [DATA_W-1:0] convResult;

  dual_conv_bus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .funcAdc(funcAdc), .chanB(chanB), .xferAdc(xferAdc),
    .convBusy(convBusy), .strb(strb), .busOe(busOe)
  );

  dual_conv_seq #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rstN(rstN), .start(strb.convStart), .chan(strb.convChan),
    .inA(adcInA), .inB(adcInB), .busy(convBusy), .done(convDone),
    .result(convResult)
  );

  dual_conv_bus_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busIn(busIn),
    .convBusy(convBusy), .convDone(convDone), .convResult(convResult),
    .dacA(dacA), .dacB(dacB), .adcLatch(busOut), .chanReg(adcChan),
    .eocN(eocN)
  );
endmodule

// File: tb/dual_conv_bus_bench.sv
module dual_conv_bus_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int CONV_CYCLES = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, wrN = 1'b1, rdN = 1'b1;
  logic       funcAdc = 1'b0, chanB = 1'b0, xferAdc = 1'b0;
  logic [7:0] adcInA = 8'h3C, adcInB = 8'hA5, busIn = 8'h00;
  logic [7:0] busOut, dacA, dacB;
  logic       busOe, eocN, adcChan;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct { string req; logic oe; logic [7:0] data; } busItem_t;
  busItem_t expQ[$];
  event sampleEv;

  dual_conv_bus #(.DATA_W(8), .CONV_CYCLES(CONV_CYCLES)) u_dual_conv_bus (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .funcAdc(funcAdc), .chanB(chanB), .xferAdc(xferAdc),
    .adcInA(adcInA), .adcInB(adcInB), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .eocN(eocN), .dacA(dacA), .dacB(dacB), .adcChan(adcChan)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard driver side: push expectation, wake monitor
  task automatic expectBus(string req, logic oe, logic [7:0] data);
    busItem_t it;
    it.req = req; it.oe = oe; it.data = data;
    expQ.push_back(it);
    #1;
    -> sampleEv;
    #1;
  endtask

  // scoreboard monitor side
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        busItem_t it;
        it = expQ.pop_front();
        checks++;
        if (busOe !== it.oe || (it.oe && busOut !== it.data)) begin
          errors++;
          $display("FAIL %s: actual oe=%b data=%h expected oe=%b data=%h",
                   it.req, busOe, busOut, it.oe, it.data);
        end
      end
    end
  end

  task automatic pulseWrite(logic cs, logic fn, logic ch, logic xf, logic [7:0] d);
    @(negedge clk);
    csN = cs; funcAdc = fn; chanB = ch; xferAdc = xf; busIn = d; wrN = 1'b0;
    @(negedge clk);
    wrN = 1'b1;
  endtask

  task automatic endAccess();
    @(negedge clk);
    csN = 1'b1;
  endtask

  task automatic readClear();
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    @(negedge clk);
    rdN = 1'b1; csN = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dacA", dacA, 8'h00);
    check("R1 dacB", dacB, 8'h00);
    check("R1 eocN", {7'd0, eocN}, 8'h01);
    check("R1 adcChan", {7'd0, adcChan}, 8'h00);
    expectBus("R1 oe", 1'b0, 8'h00);

    // R5 bus loads
    pulseWrite(1'b0, 1'b0, 1'b0, 1'b0, 8'h5A); endAccess();
    check("R5 dacA", dacA, 8'h5A);
    check("R5 dacB untouched", dacB, 8'h00);
    pulseWrite(1'b0, 1'b0, 1'b1, 1'b0, 8'hC3); endAccess();
    check("R5 dacB", dacB, 8'hC3);
    check("R5 dacA untouched", dacA, 8'h5A);

    // R2 select high
    pulseWrite(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF); endAccess();
    check("R2 dacA unchanged", dacA, 8'h5A);
    pulseWrite(1'b1, 1'b1, 1'b1, 1'b0, 8'h00); endAccess();
    repeat (CONV_CYCLES + 2) @(negedge clk);
    check("R2 no conversion", {7'd0, eocN}, 8'h01);
    check("R2 chan unchanged", {7'd0, adcChan}, 8'h00);

    // R3, R4, R11 conversion on B with read high
    pulseWrite(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
    for (int k = 1; k <= CONV_CYCLES; k++) begin
      @(negedge clk);
      if (k == 1) begin csN = 1'b1; adcInB = 8'h00; end
      check("R3 eocN high while converting", {7'd0, eocN}, 8'h01);
      expectBus("R11 port released", 1'b0, 8'h00);
    end
    @(negedge clk);
    check("R3 eocN low at completion", {7'd0, eocN}, 8'h00);
    check("R4 adcChan B", {7'd0, adcChan}, 8'h01);
    // R9 stays low without a qualified read
    repeat (3) @(negedge clk);
    rdN = 1'b0;
    @(negedge clk);
    rdN = 1'b1;
    @(negedge clk);
    check("R9 read with cs high keeps eocN", {7'd0, eocN}, 8'h00);
    // R7 read shows latched B sample
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    expectBus("R7/R4 read result B", 1'b1, 8'hA5);
    @(negedge clk);
    check("R9 eocN released by read", {7'd0, eocN}, 8'h01);
    rdN = 1'b1; csN = 1'b1;
    expectBus("R7 released", 1'b0, 8'h00);

    // R8 held read through conversion on A
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; funcAdc = 1'b1; chanB = 1'b0; wrN = 1'b0;
    @(negedge clk);
    wrN = 1'b1;
    for (int k = 1; k <= CONV_CYCLES; k++) begin
      @(negedge clk);
      expectBus("R8 previous result", 1'b1, 8'hA5);
    end
    @(negedge clk);
    check("R8 eocN low", {7'd0, eocN}, 8'h00);
    expectBus("R8 new result", 1'b1, 8'h3C);
    @(negedge clk);
    check("R9 held read does not clear", {7'd0, eocN}, 8'h00);
    rdN = 1'b1; csN = 1'b1;
    readClear();
    @(negedge clk);
    check("R9 cleared", {7'd0, eocN}, 8'h01);

    // R10 second start while busy is ignored
    adcInA = 8'h71; adcInB = 8'h99;
    pulseWrite(1'b0, 1'b1, 1'b0, 1'b0, 8'h00);       // start edge, 0 edges after drive
    @(negedge clk); csN = 1'b1;                        // k=1
    @(negedge clk);                                    // k=2
    pulseWrite(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);        // k=3,4
    for (int k = 5; k <= CONV_CYCLES; k++) begin
      @(negedge clk);
      if (k == 5) csN = 1'b1;
      check("R10 eocN still high", {7'd0, eocN}, 8'h01);
      check("R10 chan kept", {7'd0, adcChan}, 8'h00);
    end
    @(negedge clk);
    check("R10 completion time unchanged", {7'd0, eocN}, 8'h00);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    expectBus("R10 result from first start", 1'b1, 8'h71);
    @(negedge clk);
    rdN = 1'b1; csN = 1'b1;

    // R6 transfer of ADC latch into DAC A
    pulseWrite(1'b0, 1'b0, 1'b0, 1'b1, 8'hEE); endAccess();
    check("R6 dacA from latch", dacA, 8'h71);
    check("R6 dacB untouched", dacB, 8'hC3);
    pulseWrite(1'b0, 1'b0, 1'b1, 1'b1, 8'h00); endAccess();
    check("R6 dacB from latch", dacB, 8'h71);

    repeat (2) @(negedge clk);
    finish();
  end
endmodule